// File: doc/BRIEF.md
# Multi-channel UART interrupt and window hub

This block sits between a shared register bus and a bank of up to sixteen UART channels. Its own global window holds a fixed identity word, a channel-count word, a live view of the per-channel interrupt request lines, and two mask registers. One mask gates the interrupt output and the other gates the wake output. Software never writes a mask directly. One address sets bits, another clears them, so several agents can update different channels without a read-modify-write race.

The same bus address is decoded into either a global register or one channel's byte-register window. A channel window is eight byte registers placed at a fixed stride above the global area. For a channel access the hub raises exactly one channel-select line and passes on the byte offset within the window. The channel data path itself is not part of this block.

Top module: `uart_irq_hub`

## Requirements
- R1: A read at byte address 0x00 returns the identity word (default 0x0700_0001). Any other address below 0x1000 that is not one of 0x04, 0x08, 0x0C, 0x10, 0x14 or 0x18 reads as zero.
- R2: A read at 0x04 returns the configured channel count (ACTIVE_CH, default 8) in bits 4:0, with all other bits zero.
- R3: A read at 0x08 returns the status word. Bit i equals `ch_req[i]` in the same cycle for i < ACTIVE_CH. Bits at or above ACTIVE_CH read zero.
- R4: After reset the interrupt mask is zero. A write at 0x0C sets the mask bits where the write data has ones, but only for channels below ACTIVE_CH. Other bits stay unchanged. A read at 0x0C returns the mask.
- R5: A write at 0x10 clears the interrupt-mask bits where the data has ones, leaving other bits unchanged. A read at 0x10 returns zero.
- R6: The wake mask behaves the same way through 0x14 (set, reads back the mask) and 0x18 (clear, reads zero). It resets to zero.
- R7: `irq_o` is registered. One clock after any change, it equals the OR over i of status[i] AND interrupt-mask[i].
- R8: `wake_o` is registered. One clock after any change, it equals the OR over i of status[i] AND wake-mask[i].
- R9: `ch_sel[i]` is high exactly when `bus_sel` is high, i < ACTIVE_CH, and the address lies in 0x1000 + 0x200*i through 0x1000 + 0x200*i + 7. At most one select is high. `ch_off` equals address bits 2:0.
- R10: Writes to 0x00, 0x04 or 0x08, and any write with `bus_sel` low, leave both masks unchanged.
- R11: `bus_rdata` is zero for any address at or above 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of global window (combinational) |
| ch_req | input | NUM_CH (16) | Per-channel interrupt request lines |
| ch_sel | output | NUM_CH (16) | One-hot channel window select |
| ch_off | output | CH_OFF_W (3) | Byte offset inside channel window |
| irq_o | output | 1 | Combined masked interrupt |
| wake_o | output | 1 | Combined masked wake request |

## Verification
A wrong mask bit shows at the ports in two ways. A read of 0x0C or 0x14 exposes it in the same cycle. `irq_o` or `wake_o` exposes it one clock after the corresponding request line rises. The bench therefore sweeps all 65536 request patterns against fixed masks and compares status and both outputs on every vector. A decode error in the channel windows appears as a wrong or missing select on the very address that hits it, so every window is probed at its edges and just beyond them.

// File: rtl/uart_hub_pkg.sv
// Package: shared constants and types for the UART interrupt hub.
// Assumes 32-bit global registers on a byte-addressed bus.
package uart_hub_pkg;

    localparam int DATA_W = 32;

    // Byte offsets of the global registers
    localparam int OFS_IDENT = 'h00;
    localparam int OFS_COUNT = 'h04;
    localparam int OFS_STAT  = 'h08;
    localparam int OFS_IEN   = 'h0C;
    localparam int OFS_IDIS  = 'h10;
    localparam int OFS_WEN   = 'h14;
    localparam int OFS_WDIS  = 'h18;

    // Global register selected by the current address
    typedef enum logic [2:0] {
        G_IDENT,
        G_COUNT,
        G_STAT,
        G_IEN,
        G_IDIS,
        G_WEN,
        G_WDIS,
        G_NONE
    } gsel_e;

endpackage

// File: rtl/uart_hub_addr_dec.sv
// Address decoder: maps a byte address to a global register or to one
// channel's byte-register window. Assumes ADDR_W <= 32 and that all
// windows fit in the address space.
module uart_hub_addr_dec
    import uart_hub_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_CH    = 16,
    parameter int ACTIVE_CH = 8,
    parameter int CH_BASE   = 'h1000,
    parameter int CH_STRIDE = 'h200,
    parameter int CH_REGS   = 8,
    parameter int CH_OFF_W  = 3
) (
    input  logic                bus_sel,
    input  logic [ADDR_W-1:0]   bus_addr,
    output gsel_e               gsel,
    output logic [NUM_CH-1:0]   ch_sel,
    output logic [CH_OFF_W-1:0] ch_off
);

    localparam logic [31:0] BASE32 = 32'(CH_BASE);

    logic [31:0] addr32;

    assign addr32 = 32'(bus_addr);
    assign ch_off = bus_addr[CH_OFF_W-1:0];

    // Global register select: word-aligned hits inside the global area only
    always_comb begin
        gsel = G_NONE;
        if (addr32 < BASE32) begin
            case (addr32)
                32'(OFS_IDENT): gsel = G_IDENT;
                32'(OFS_COUNT): gsel = G_COUNT;
                32'(OFS_STAT):  gsel = G_STAT;
                32'(OFS_IEN):   gsel = G_IEN;
                32'(OFS_IDIS):  gsel = G_IDIS;
                32'(OFS_WEN):   gsel = G_WEN;
                32'(OFS_WDIS):  gsel = G_WDIS;
                default:        gsel = G_NONE;
            endcase
        end
    end

    // One comparator pair per channel window; channels above the count never select
    for (genvar i = 0; i < NUM_CH; i++) begin : g_win
        localparam logic [31:0] LO = 32'(CH_BASE + CH_STRIDE * i);
        localparam logic [31:0] HI = 32'(CH_BASE + CH_STRIDE * i + CH_REGS);
        if (i < ACTIVE_CH) begin : g_live
            assign ch_sel[i] = bus_sel && (addr32 >= LO) && (addr32 < HI);
        end else begin : g_dead
            assign ch_sel[i] = 1'b0;
        end
    end

endmodule

// File: rtl/uart_hub_mask_reg.sv
// Mask register changed only through write-one-to-set and
// write-one-to-clear strobes. Assumes set and clear never arrive together
// (they come from different addresses); set wins if they do.
module uart_hub_mask_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] allow,
    output logic [W-1:0] mask
);

    // Hold, set or clear the mask bits selected by the write data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (set_we) begin
            mask <= mask | (wdata & allow);
        end else if (clr_we) begin
            mask <= mask & ~wdata;
        end
    end

endmodule

// File: rtl/uart_hub_rd_mux.sv
// Read multiplexer for the global window. Clear-address reads and
// unmapped addresses return zero. Assumes NUM_CH < 32.
module uart_hub_rd_mux
    import uart_hub_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  gsel_e              gsel,
    input  logic [DATA_W-1:0]  ident,
    input  logic [DATA_W-1:0]  count,
    input  logic [NUM_CH-1:0]  status,
    input  logic [NUM_CH-1:0]  int_mask,
    input  logic [NUM_CH-1:0]  wake_mask,
    output logic [DATA_W-1:0]  rdata
);

    // Select the word for the addressed global register
    always_comb begin
        case (gsel)
            G_IDENT: rdata = ident;
            G_COUNT: rdata = count;
            G_STAT:  rdata = DATA_W'(status);
            G_IEN:   rdata = DATA_W'(int_mask);
            G_WEN:   rdata = DATA_W'(wake_mask);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_irq_hub.sv
// Top: global control window of a multi-channel UART bank. Collects the
// channel request lines, applies interrupt and wake masks, drives the
// combined registered outputs and decodes the channel windows.
// Assumes NUM_CH <= 16 and ACTIVE_CH <= NUM_CH.
module uart_irq_hub
    import uart_hub_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          NUM_CH    = 16,
    parameter int          ACTIVE_CH = 8,
    parameter int          CH_BASE   = 'h1000,
    parameter int          CH_STRIDE = 'h200,
    parameter int          CH_REGS   = 8,
    parameter int          CH_OFF_W  = $clog2(CH_REGS),
    parameter logic [31:0] IDENT     = 32'h0700_0001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_CH-1:0]   ch_req,
    output logic [NUM_CH-1:0]   ch_sel,
    output logic [CH_OFF_W-1:0] ch_off,
    output logic                irq_o,
    output logic                wake_o
);

    localparam logic [DATA_W-1:0] COUNT_WORD = DATA_W'(5'(ACTIVE_CH));

    gsel_e             gsel;
    logic              wr;
    logic [NUM_CH-1:0] act_bits;
    logic [NUM_CH-1:0] status;
    logic [NUM_CH-1:0] int_mask;
    logic [NUM_CH-1:0] wake_mask;

    // Channels that exist in this configuration
    for (genvar i = 0; i < NUM_CH; i++) begin : g_act
        assign act_bits[i] = (i < ACTIVE_CH);
    end

    assign wr     = bus_sel && bus_we;
    assign status = ch_req & act_bits;

    uart_hub_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_CH    (NUM_CH),
        .ACTIVE_CH (ACTIVE_CH),
        .CH_BASE   (CH_BASE),
        .CH_STRIDE (CH_STRIDE),
        .CH_REGS   (CH_REGS),
        .CH_OFF_W  (CH_OFF_W)
    ) u_dec (
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .gsel     (gsel),
        .ch_sel   (ch_sel),
        .ch_off   (ch_off)
    );

    uart_hub_mask_reg #(.W(NUM_CH)) u_int_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr && gsel == G_IEN),
        .clr_we (wr && gsel == G_IDIS),
        .wdata  (bus_wdata[NUM_CH-1:0]),
        .allow  (act_bits),
        .mask   (int_mask)
    );

    uart_hub_mask_reg #(.W(NUM_CH)) u_wake_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr && gsel == G_WEN),
        .clr_we (wr && gsel == G_WDIS),
        .wdata  (bus_wdata[NUM_CH-1:0]),
        .allow  (act_bits),
        .mask   (wake_mask)
    );

    uart_hub_rd_mux #(.NUM_CH(NUM_CH)) u_rd (
        .gsel      (gsel),
        .ident     (IDENT),
        .count     (COUNT_WORD),
        .status    (status),
        .int_mask  (int_mask),
        .wake_mask (wake_mask),
        .rdata     (bus_rdata)
    );

    // Register the combined masked interrupt and wake requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            irq_o  <= |(status & int_mask);
            wake_o <= |(status & wake_mask);
        end
    end

endmodule

// File: rtl/uart_irq_hub_chk.sv
// Checker bound to uart_irq_hub: relates bus writes, mask state,
// request lines and the registered outputs over time.
module uart_irq_hub_chk #(
    parameter int ADDR_W    = 16,
    parameter int NUM_CH    = 16,
    parameter int ACTIVE_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NUM_CH-1:0] ch_req,
    input logic [NUM_CH-1:0] ch_sel,
    input logic [NUM_CH-1:0] int_mask,
    input logic [NUM_CH-1:0] wake_mask,
    input logic              irq_o,
    input logic              wake_o
);

    localparam logic [NUM_CH-1:0] LIVE = NUM_CH'((33'd1 << ACTIVE_CH) - 33'd1);

    logic wr_any;
    assign wr_any = bus_sel && bus_we;

    p_onehot_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_sel));

    p_no_sel_global_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bus_addr) < 32'h1000) |-> (ch_sel == '0));

    p_set_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'('h0C)) |=>
        (int_mask == ($past(int_mask) | ($past(bus_wdata[NUM_CH-1:0]) & LIVE))));

    p_clr_int_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'('h10)) |=>
        (int_mask == ($past(int_mask) & ~$past(bus_wdata[NUM_CH-1:0]))));

    p_set_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'('h14)) |=>
        (wake_mask == ($past(wake_mask) | ($past(bus_wdata[NUM_CH-1:0]) & LIVE))));

    p_ro_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_any || bus_addr < ADDR_W'('h0C)) |=>
        ($stable(int_mask) && $stable(wake_mask)));

    p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == ($past(ch_req & int_mask & LIVE) != '0)));

    p_wake_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wake_o == ($past(ch_req & wake_mask & LIVE) != '0)));

endmodule

bind uart_irq_hub uart_irq_hub_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_CH    (NUM_CH),
    .ACTIVE_CH (ACTIVE_CH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ch_req    (ch_req),
    .ch_sel    (ch_sel),
    .int_mask  (int_mask),
    .wake_mask (wake_mask),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
);

// File: tb/uart_irq_hub_bench.sv
// Bench: near-exhaustive sweeps over the default configuration
// (16 channel slots, 8 live channels) with arithmetic expected values.
module uart_irq_hub_bench;

    localparam int LIVE_N = 8;
    localparam logic [15:0] LIVE = 16'h00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] ch_req = '0;
    logic [15:0] ch_sel;
    logic [2:0]  ch_off;
    logic        irq_o;
    logic        wake_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [15:0] m_int = '0;
    logic [15:0] m_wake = '0;

    always #5 clk = ~clk;

    uart_irq_hub u_uart_irq_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_req    (ch_req),
        .ch_sel    (ch_sel),
        .ch_off    (ch_off),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input bit sel);
        @(negedge clk);
        bus_sel = sel; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_int(input logic [31:0] d);
        bus_write(16'h000C, d, 1'b1); m_int = m_int | (d[15:0] & LIVE);
    endtask
    task automatic clr_int(input logic [31:0] d);
        bus_write(16'h0010, d, 1'b1); m_int = m_int & ~d[15:0];
    endtask
    task automatic set_wake(input logic [31:0] d);
        bus_write(16'h0014, d, 1'b1); m_wake = m_wake | (d[15:0] & LIVE);
    endtask
    task automatic clr_wake(input logic [31:0] d);
        bus_write(16'h0018, d, 1'b1); m_wake = m_wake & ~d[15:0];
    endtask

    task automatic check_masks(input string tag);
        logic [31:0] d;
        bus_read(16'h000C, d); check(d == {16'h0, m_int}, tag, d, {16'h0, m_int});
        bus_read(16'h0014, d); check(d == {16'h0, m_wake}, tag, d, {16'h0, m_wake});
        bus_read(16'h0010, d); check(d == 32'h0, "R5", d, 32'h0);
        bus_read(16'h0018, d); check(d == 32'h0, "R6", d, 32'h0);
    endtask

    // Sweep request patterns; outputs checked one clock after each vector
    task automatic req_sweep(input int step);
        logic [15:0] prev;
        bit have_prev;
        logic [15:0] st;
        have_prev = 1'b0;
        prev = '0;
        for (int v = 0; v < 65536; v += step) begin
            @(negedge clk);
            if (have_prev) begin
                check(irq_o == |(prev & LIVE & m_int), "R7", 32'(irq_o), 32'(|(prev & LIVE & m_int)));
                check(wake_o == |(prev & LIVE & m_wake), "R8", 32'(wake_o), 32'(|(prev & LIVE & m_wake)));
            end
            ch_req = v[15:0];
            bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 16'h0008;
            #1 st = v[15:0] & LIVE;
            check(bus_rdata == {16'h0, st}, "R3", bus_rdata, {16'h0, st});
            prev = v[15:0];
            have_prev = 1'b1;
        end
        @(negedge clk);
        check(irq_o == |(prev & LIVE & m_int), "R7", 32'(irq_o), 32'(|(prev & LIVE & m_int)));
        check(wake_o == |(prev & LIVE & m_wake), "R8", 32'(wake_o), 32'(|(prev & LIVE & m_wake)));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [15:0] lfsr;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R4, R6, R7, R8)
        @(negedge clk);
        check(irq_o == 1'b0, "R7", 32'(irq_o), 0);
        check(wake_o == 1'b0, "R8", 32'(wake_o), 0);
        check_masks("R4");

        // R1: identity and unmapped global words
        bus_read(16'h0000, d); check(d == 32'h0700_0001, "R1", d, 32'h0700_0001);
        for (int a = 'h1C; a < 'h1000; a += 4) begin
            bus_read(16'(a), d); check(d == 32'h0, "R1", d, 32'h0);
        end
        bus_read(16'h0006, d); check(d == 32'h0, "R1", d, 32'h0);

        // R2: channel count
        bus_read(16'h0004, d); check(d == 32'(LIVE_N), "R2", d, 32'(LIVE_N));

        // R11: reads in channel space return zero
        bus_read(16'h1000, d); check(d == 32'h0, "R11", d, 32'h0);
        bus_read(16'h2E07, d); check(d == 32'h0, "R11", d, 32'h0);

        // R4/R5/R6: walk each bit through set and clear
        for (int i = 0; i < 16; i++) begin
            set_int(32'h1 << i);  check_masks("R4");
            set_wake(32'h1 << i); check_masks("R6");
        end
        for (int i = 0; i < 16; i++) begin
            clr_int(32'h1 << i);  check_masks("R5");
            clr_wake(32'h1 << i); check_masks("R6");
        end
        lfsr = 16'hACE1;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) set_int({16'hFFFF, lfsr}); else clr_int({16'h0, lfsr});
            if (lfsr[1]) set_wake({16'h0, ~lfsr}); else clr_wake({16'hFFFF, ~lfsr});
            check_masks("R4");
        end

        // R10: writes to read-only words or without select change nothing
        set_int(32'h0000_00A5); set_wake(32'h0000_003C);
        bus_write(16'h0000, 32'hFFFF_FFFF, 1'b1);
        bus_write(16'h0004, 32'hFFFF_FFFF, 1'b1);
        bus_write(16'h0008, 32'hFFFF_FFFF, 1'b1);
        bus_write(16'h000C, 32'hFFFF_FFFF, 1'b0);
        bus_write(16'h0010, 32'hFFFF_FFFF, 1'b0);
        bus_write(16'h0018, 32'hFFFF_FFFF, 1'b0);
        check_masks("R10");

        // R3/R7/R8: full request sweep, then a strided sweep with other masks
        clr_int(32'hFFFF); clr_wake(32'hFFFF);
        set_int(32'h0000_5A5A); set_wake(32'h0000_FF81);
        req_sweep(1);
        clr_int(32'h0000_FFFF); set_int(32'h0000_0080);
        clr_wake(32'h0000_00FF); set_wake(32'h0000_0001);
        req_sweep(5);
        ch_req = '0;

        // R9: probe every window around its edges
        for (int c = 0; c < 16; c++) begin
            for (int o = -1; o < 10; o++) begin
                int a;
                logic [15:0] exp_sel;
                a = 'h1000 + 'h200 * c + o;
                exp_sel = (c < LIVE_N && o >= 0 && o < 8) ? (16'h1 << c) : 16'h0;
                @(negedge clk);
                bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 16'(a);
                #1;
                check(ch_sel == exp_sel, "R9", 32'(ch_sel), 32'(exp_sel));
                check(ch_off == 3'(a), "R9", 32'(ch_off), 32'(3'(a)));
            end
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_addr = 16'h1003;
        #1 check(ch_sel == 16'h0, "R9", 32'(ch_sel), 0);
        bus_sel = 1'b1; bus_addr = 16'h0003;
        #1 check(ch_sel == 16'h0, "R9", 32'(ch_sel), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule